// File: doc/BRIEF.md
# Head Step Pulse Sequencer

This block moves a floppy drive's head by a programmed number of tracks. It sends a train of one-cycle step strobes to the drive. Software first loads a step count. It sets the phase and mode lines so that they address the drive's step command, and then raises a start request. If the request is accepted, the first strobe goes out on the next clock edge. Each later strobe follows a fixed interval after the one before it. The interval is given in clock cycles and by default equals 80 microseconds.

Every strobe takes one from the remaining count. The strobe that brings the count to zero ends the run and sets a sticky completion flag, which stays set until it is cleared. A halt request ends a run early and empties the count, and it does not set the flag.

A start request is refused in four cases: the count is zero, a run is already going, the disk-access engine is busy, or the command lines do not select the step command. A refused request changes nothing.

Top module: `step_seq`

## Requirements
- R1: After reset, `stepping`, `step_strobe` and `done_flag` are 0 and `steps_left` is 0.
- R2: A start request made while `steps_left` is 0 is refused: no strobe and `stepping` stays 0.
- R3: A start request is refused while `access_busy` is 1. A start request made while a run is active does not restart it and does not shift the strobe timing.
- R4: A start request is refused unless the 3-bit command address {`cmd_hi`, `phase_lo[1:0]`} equals STEP_CMD (default 3'b100, that is `cmd_hi`=1 and `phase_lo`=00).
- R5: On an accepted start, `step_strobe` is 1 in the cycle right after the clock edge that samples the request, and `stepping` rises in that same cycle.
- R6: Later strobes come exactly PERIOD = CLK_MHZ*STEP_US cycles apart, and each strobe is one cycle wide.
- R7: Each strobe lowers `steps_left` by one. The strobe that brings it to zero also clears `stepping` and sets `done_flag` on the same edge.
- R8: `halt_req` during a run clears `stepping` and `steps_left` on the next edge. No further strobes follow, and `done_flag` is not set.
- R9: `done_flag` stays 1 until `flag_clr`. When a clear and a completion fall on the same edge, the flag ends up 1.
- R10: `cnt_wr` loads `cnt_wdata` into `steps_left` only while no run is active. During a run the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr | input | 1 | Write strobe for the step count |
| cnt_wdata | input | CNT_W | Step count value to load |
| go_req | input | 1 | Start request |
| halt_req | input | 1 | Halt request |
| cmd_hi | input | 1 | High bit of the command address (mode select) |
| phase_lo | input | 2 | Low bits of the command address (phase lines) |
| access_busy | input | 1 | Disk-access engine is active |
| flag_clr | input | 1 | Clears the completion flag |
| step_strobe | output | 1 | One-cycle step pulse to the drive |
| stepping | output | 1 | A run is active |
| steps_left | output | CNT_W | Remaining step count |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with CLK_MHZ=1, STEP_US=6 and CNT_W=4. That makes the interval 6 cycles, so multi-step runs, a halt partway through a run, and a start request repeated mid-run all fit in a few hundred cycles. A scoreboard predicts the exact cycle of every strobe. Any strobe that comes out of a refused start or after a halt is therefore caught, and so is one that drifts from its predicted cycle.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // reasons a start request can be turned down
    typedef struct packed {
        logic no_steps;
        logic running;
        logic engine_busy;
        logic wrong_cmd;
    } refuse_t;

    function automatic logic [2:0] make_cmd(input logic hi, input logic [1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic any_refusal(input refuse_t r);
        return r.no_steps | r.running | r.engine_busy | r.wrong_cmd;
    endfunction

endpackage

// File: rtl/step_gate.sv
module step_gate
    import step_seq_pkg::*;
#(
    parameter logic [2:0] STEP_CMD = 3'b100
) (
    input  logic       go_req,
    input  seq_state_e state,
    input  logic       cnt_zero,
    input  logic       access_busy,
    input  logic       cmd_hi,
    input  logic [1:0] phase_lo,
    output logic       accept
);
    refuse_t why;

    always_comb begin
        why.no_steps    = cnt_zero;
        why.running     = (state == SEQ_RUN);
        why.engine_busy = access_busy;
        why.wrong_cmd   = (make_cmd(cmd_hi, phase_lo) != STEP_CMD);
        accept          = go_req && !any_refusal(why);
    end
endmodule

// File: rtl/step_interval.sv
module step_interval #(
    parameter int PERIOD = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic run,
    output logic tick
);
    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] TOP = TW'(PERIOD - 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (reload) begin
            remain <= TOP;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign tick = run && (remain == '0);
endmodule

// File: rtl/step_count_reg.sv
module step_count_reg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             dec,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (dec) begin
            count <= count - ONE;
        end else if (wr) begin
            count <= wdata;
        end
    end

    assign is_zero = (count == '0);
    assign is_last = (count == ONE);
endmodule

// File: rtl/step_seq.sv
module step_seq
    import step_seq_pkg::*;
#(
    parameter int         CNT_W    = 8,
    parameter int         CLK_MHZ  = 100,
    parameter int         STEP_US  = 80,
    parameter logic [2:0] STEP_CMD = 3'b100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             go_req,
    input  logic             halt_req,
    input  logic             cmd_hi,
    input  logic [1:0]       phase_lo,
    input  logic             access_busy,
    input  logic             flag_clr,
    output logic             step_strobe,
    output logic             stepping,
    output logic [CNT_W-1:0] steps_left,
    output logic             done_flag
);
    localparam int PERIOD = CLK_MHZ * STEP_US;

    seq_state_e state;
    logic       accept, tick, cnt_zero, cnt_last;
    logic       fire, abort;

    step_gate #(.STEP_CMD(STEP_CMD)) u_gate (
        .go_req      (go_req),
        .state       (state),
        .cnt_zero    (cnt_zero),
        .access_busy (access_busy),
        .cmd_hi      (cmd_hi),
        .phase_lo    (phase_lo),
        .accept      (accept)
    );

    always_comb begin
        abort = (state == SEQ_RUN) && halt_req;
        fire  = (state == SEQ_IDLE) ? accept : (!halt_req && tick);
    end

    step_interval #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .reload (fire),
        .run    (state == SEQ_RUN),
        .tick   (tick)
    );

    step_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .clear   (abort),
        .dec     (fire),
        .wr      (cnt_wr && state == SEQ_IDLE),
        .wdata   (cnt_wdata),
        .count   (steps_left),
        .is_zero (cnt_zero),
        .is_last (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            step_strobe <= 1'b0;
            done_flag   <= 1'b0;
        end else begin
            step_strobe <= fire;
            if (abort) begin
                state <= SEQ_IDLE;
            end else if (fire) begin
                state <= cnt_last ? SEQ_IDLE : SEQ_RUN;
            end
            if (fire && cnt_last) begin
                done_flag <= 1'b1;
            end else if (flag_clr) begin
                done_flag <= 1'b0;
            end
        end
    end

    assign stepping = (state == SEQ_RUN);
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
    parameter int CNT_W  = 8,
    parameter int PERIOD = 8000
) (
    input logic             clk,
    input logic             rst,
    input logic             go_req,
    input logic             halt_req,
    input logic             access_busy,
    input logic             cnt_wr,
    input logic             step_strobe,
    input logic             stepping,
    input logic [CNT_W-1:0] steps_left,
    input logic             done_flag
);
    AST_RUN_STARTS_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(stepping) |-> step_strobe); // R5

    AST_FIRST_STROBE_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        (step_strobe && !$past(stepping)) |-> $past(go_req)); // R5

    AST_STROBE_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        step_strobe |-> (steps_left == $past(steps_left) - 1'b1)); // R7

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> (steps_left == '0 && !stepping)); // R7

    AST_REFUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (go_req && !stepping && steps_left == '0) |=> !stepping); // R2

    AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (go_req && !stepping && access_busy) |=> (!stepping && !step_strobe)); // R3

    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stepping && halt_req) |=> (!stepping && steps_left == '0 && !step_strobe)); // R8

    AST_WRITE_IGNORED_RUN: assert property (@(posedge clk) disable iff (rst)
        (stepping && cnt_wr && !halt_req) |=> (step_strobe || $stable(steps_left))); // R10

    generate
        if (PERIOD > 1) begin : g_width
            AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
                (step_strobe && stepping) |=> !step_strobe); // R6
        end
    endgenerate
endmodule

bind step_seq step_seq_chk #(.CNT_W(CNT_W), .PERIOD(CLK_MHZ * STEP_US)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .go_req      (go_req),
    .halt_req    (halt_req),
    .access_busy (access_busy),
    .cnt_wr      (cnt_wr),
    .step_strobe (step_strobe),
    .stepping    (stepping),
    .steps_left  (steps_left),
    .done_flag   (done_flag)
);

// File: tb/step_seq_test.sv
module step_seq_test;
    localparam int CW = 4;
    localparam int P  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          go_req = 1'b0;
    logic          halt_req = 1'b0;
    logic          cmd_hi = 1'b1;
    logic [1:0]    phase_lo = 2'b00;
    logic          access_busy = 1'b0;
    logic          flag_clr = 1'b0;
    logic          step_strobe, stepping, done_flag;
    logic [CW-1:0] steps_left;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int expq[$];
    bit finished = 0;

    step_seq #(.CNT_W(CW), .CLK_MHZ(1), .STEP_US(P), .STEP_CMD(3'b100)) uut (
        .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .go_req(go_req), .halt_req(halt_req), .cmd_hi(cmd_hi),
        .phase_lo(phase_lo), .access_busy(access_busy), .flag_clr(flag_clr),
        .step_strobe(step_strobe), .stepping(stepping),
        .steps_left(steps_left), .done_flag(done_flag)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // scoreboard monitor: every strobe must match the next predicted cycle
    always @(negedge clk) begin
        if (!rst && step_strobe) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2/R3/R4/R8 unexpected strobe", cyc, -1);
            end else begin
                int e;
                e = expq.pop_front();
                chk(cyc == e, "R5/R6 strobe cycle", cyc, e);
            end
        end
    end

    task automatic load(input int n);
        cnt_wr = 1'b1; cnt_wdata = CW'(n);
        tick();
        cnt_wr = 1'b0;
    endtask

    // request a start; push predicted strobe cycles when acceptance is expected
    task automatic start(input int n_expected);
        for (int i = 0; i < n_expected; i++) expq.push_back(cyc + 1 + i * P);
        go_req = 1'b1;
        tick();
        go_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        chk(!stepping && !step_strobe && !done_flag, "R1 reset outputs", {stepping, step_strobe, done_flag}, 0);
        chk(steps_left == 0, "R1 reset count", steps_left, 0);

        // R2 zero count refused
        start(0);
        chk(!stepping, "R2 zero count refused", stepping, 0);
        tick(P + 2);

        // R10 load while idle
        load(3);
        chk(steps_left == 3, "R10 idle load", steps_left, 3);

        // R3 busy refused
        access_busy = 1'b1;
        start(0);
        chk(!stepping && steps_left == 3, "R3 busy refused", stepping, 0);
        access_busy = 1'b0;

        // R4 wrong command address refused
        cmd_hi = 1'b0;
        start(0);
        chk(!stepping, "R4 cmd_hi low refused", stepping, 0);
        cmd_hi = 1'b1; phase_lo = 2'b01;
        start(0);
        chk(!stepping, "R4 phase 01 refused", stepping, 0);
        phase_lo = 2'b00;
        tick(P + 2);

        // R5 R6 R7 three-step run
        start(3);
        chk(stepping && step_strobe, "R5 immediate strobe", {stepping, step_strobe}, 3);
        chk(steps_left == 2, "R7 first decrement", steps_left, 2);
        tick(2 * P);
        chk(step_strobe && !stepping, "R7 last strobe ends run", {step_strobe, stepping}, 2);
        chk(steps_left == 0 && done_flag, "R7 done at zero", {steps_left, done_flag}, 1);
        tick(P + 2);
        chk(done_flag, "R9 flag sticky", done_flag, 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk(!done_flag, "R9 flag cleared", done_flag, 0);

        // R9 set wins over clear on the same edge (single step run)
        load(1);
        flag_clr = 1'b1;
        start(1);
        flag_clr = 1'b0;
        chk(done_flag && !stepping, "R9 set beats clear", done_flag, 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;

        // R8 R10 R3: halt mid-run, write ignored, restart ignored
        load(5);
        start(5);
        tick(P);                      // second strobe
        cnt_wr = 1'b1; cnt_wdata = 4'd9;
        tick();
        cnt_wr = 1'b0;
        chk(steps_left == 3, "R10 write ignored during run", steps_left, 3);
        go_req = 1'b1; tick(); go_req = 1'b0;  // R3 restart attempt while running
        tick(P - 2);                  // third strobe
        chk(step_strobe && steps_left == 2, "R3 timing unchanged by restart", steps_left, 2);
        halt_req = 1'b1; tick(); halt_req = 1'b0;
        expq.delete();
        chk(!stepping && steps_left == 0, "R8 halt clears", {stepping, steps_left}, 0);
        chk(!done_flag, "R8 halt leaves flag", done_flag, 0);
        tick(3 * P);
        chk(!stepping, "R8 stays idle", stepping, 0);

        chk(expq.size() == 0, "R6 all predicted strobes seen", expq.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule